// File: doc/BRIEF.md
# Child Result Return Latch

This block lives inside a parent core that delegates code fragments to child cores. When the parent hires a child into one of its slots, it records a register mask naming the registers that child owes back. As the child terminates it sends those register values one at a time. They are parked in a latch bank that belongs to the slot, and never go straight into the parent's working register file.

The parent decides when the parked values become visible. It issues a clone command for a slot together with a selection of registers. The block then streams the selected, owed registers into the register file, one per cycle, through a write port. When that finishes, the slot is released for a new child.

The block also tracks every child that still owes results. A request by the parent to end its own fragment is held off with a wait output until none are left.

Top module: `child_return_latch`

## Requirements
- R1: A hire request to a free slot records its register mask, and from the next cycle the slot's bit in `outstanding` is set unless the mask is all zero.
- R2: A hire request to a slot that is still occupied changes nothing: the earlier mask stays in force.
- R3: A returned register value is latched only when all of these hold: the slot is occupied, the register's bit is set in the slot mask, and the slot has not yet completed its return. Any other return write is ignored.
- R4: A slot counts as returned (bit set in `slot_returned`, cleared in `outstanding`) in the cycle after the last register of its mask is latched. A slot hired with an all-zero mask is returned in the cycle right after the hire.
- R5: `rf_we` is asserted only while a clone copy is running. Returned values reach the register file by no other path.
- R6: A clone request for a returned slot while no copy is running is accepted in its cycle with `clone_stall` low. From the next cycle, the block writes the registers in the selection ANDed with the slot mask, one per cycle, in ascending register index, each with the value latched for that slot.
- R7: A clone request is stalled (`clone_stall` high in the same cycle) while its slot is not returned or a copy is running.
- R8: A slot is freed when its clone completes: in the cycle after its last copy write, or in the cycle after acceptance when nothing is selected. Once freed, its `slot_returned` bit is clear and a new hire to it is accepted.
- R9: `end_wait` equals `end_req` while any slot is outstanding, and `end_grant` equals `end_req` while none is.
- R10: After reset, no slot is occupied, `outstanding` and `slot_returned` are zero and `rf_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hire_valid | input | 1 | Record a new child in a slot |
| hire_slot | input | SLOT_W | Slot for the new child |
| hire_mask | input | NUM_REGS | Registers the child must return |
| ret_valid | input | 1 | A child returns one register value |
| ret_slot | input | SLOT_W | Slot of the returning child |
| ret_reg | input | REG_W | Register index being returned |
| ret_data | input | DATA_W | Returned register value |
| clone_valid | input | 1 | Parent requests a copy into its registers |
| clone_slot | input | SLOT_W | Slot to copy from |
| clone_sel | input | NUM_REGS | Registers to copy |
| clone_stall | output | 1 | Clone request not accepted this cycle |
| rf_we | output | 1 | Register file write enable |
| rf_addr | output | REG_W | Register file write index |
| rf_data | output | DATA_W | Register file write value |
| end_req | input | 1 | Parent asks to end its fragment |
| end_wait | output | 1 | End request held: children still owe results |
| end_grant | output | 1 | End request may proceed |
| outstanding | output | NUM_SLOTS | Occupied slots whose return is incomplete |
| slot_returned | output | NUM_SLOTS | Occupied slots whose return is complete |

## Verification
Directed sequences come first. One slot receives an unmasked write, a write after completion and a second hire. Then one clone reveals exactly which values were kept, which tells R2 and R3 apart from a design that accepts every write. An all-zero mask and an empty clone selection cover the immediate-return and immediate-free corners. Random traffic follows, with sparse masks, returns steered towards owed registers, clones on slots at every stage and a random end request each cycle. It checks stall decisions, write order and data, and the outstanding and returned masks against a bench model, and so separates stalls caused by incomplete returns from normal acceptance.

// File: rtl/crl_pkg.sv
// Shared definitions for the child result return latch.
// Assumes: nothing beyond IEEE 1800-2017.
package crl_pkg;
    localparam int unsigned DEF_SLOTS  = 8;
    localparam int unsigned DEF_REGS   = 16;
    localparam int unsigned DEF_DATA_W = 32;

    // State of the clone copy engine.
    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_COPY = 1'b1
    } eng_state_e;
endpackage

// File: rtl/crl_slot_table.sv
// Per-slot bookkeeping: occupancy, owed-register mask and latched-valid bits.
// Decides which hire and return writes are accepted and which slots are complete.
// Assumes: a free request only names a slot that is occupied and returned.
module crl_slot_table #(
    parameter int unsigned NUM_SLOTS = crl_pkg::DEF_SLOTS,
    parameter int unsigned NUM_REGS  = crl_pkg::DEF_REGS,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
    localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               hire_valid,
    input  logic [SLOT_W-1:0]                  hire_slot,
    input  logic [NUM_REGS-1:0]                hire_mask,
    input  logic                               ret_valid,
    input  logic [SLOT_W-1:0]                  ret_slot,
    input  logic [REG_W-1:0]                   ret_reg,
    input  logic                               free_valid,
    input  logic [SLOT_W-1:0]                  free_slot,
    output logic                               ret_accept,
    output logic [NUM_SLOTS-1:0][NUM_REGS-1:0] mask_o,
    output logic [NUM_SLOTS-1:0]               busy_o,
    output logic [NUM_SLOTS-1:0]               returned_o
);
    logic [NUM_SLOTS-1:0]               busy_q;
    logic [NUM_SLOTS-1:0][NUM_REGS-1:0] mask_q;
    logic [NUM_SLOTS-1:0][NUM_REGS-1:0] vld_q;
    logic                               hire_ok;

    // A slot is complete once every owed register has been latched.
    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_done
            assign returned_o[s] = busy_q[s] && (vld_q[s] == mask_q[s]);
        end
    endgenerate

    // Acceptance of hire and return writes.
    always_comb begin
        hire_ok    = hire_valid && !busy_q[hire_slot];
        ret_accept = ret_valid && busy_q[ret_slot]
                     && mask_q[ret_slot][ret_reg] && !returned_o[ret_slot];
    end

    // Slot state update: hire, latch-valid marking and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            mask_q <= '0;
            vld_q  <= '0;
        end else begin
            if (hire_ok) begin
                busy_q[hire_slot] <= 1'b1;
                mask_q[hire_slot] <= hire_mask;
                vld_q[hire_slot]  <= '0;
            end
            if (ret_accept) begin
                vld_q[ret_slot][ret_reg] <= 1'b1;
            end
            if (free_valid) begin
                busy_q[free_slot] <= 1'b0;
                vld_q[free_slot]  <= '0;
            end
        end
    end

    assign mask_o = mask_q;
    assign busy_o = busy_q;

    // R2: a hire to an occupied slot leaves its mask untouched.
    p_busy_hire_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hire_valid && busy_q[hire_slot]
        |=> mask_q[$past(hire_slot)] == $past(mask_q[hire_slot]))
        else $error("hire overwrote an occupied slot");

    // R3: a write to an unowed register never marks it latched.
    p_unowed_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid && busy_q[ret_slot] && !mask_q[ret_slot][ret_reg]
        |=> !vld_q[$past(ret_slot)][$past(ret_reg)])
        else $error("unowed register marked latched");

    // R8: release only ever hits a complete slot.
    p_free_complete_r8: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> returned_o[free_slot])
        else $error("release of an incomplete slot");
endmodule

// File: rtl/crl_latch_bank.sv
// Storage of returned register values: one bank of NUM_REGS words per slot.
// Write is gated by the slot table; the read port is combinational.
// Assumes: reads only target entries that were written since the last hire.
module crl_latch_bank #(
    parameter int unsigned NUM_SLOTS = crl_pkg::DEF_SLOTS,
    parameter int unsigned NUM_REGS  = crl_pkg::DEF_REGS,
    parameter int unsigned DATA_W    = crl_pkg::DEF_DATA_W,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
    localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [REG_W-1:0]  rd_reg,
    output logic [DATA_W-1:0] rd_data
);
    logic [NUM_REGS-1:0][DATA_W-1:0] bank_rd [NUM_SLOTS];

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_bank
            logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;

            // Capture a returned value into this slot's bank.
            always_ff @(posedge clk) begin
                if (wr_en && (wr_slot == SLOT_W'(s))) begin
                    bank_q[wr_reg] <= wr_data;
                end
            end

            assign bank_rd[s] = bank_q;
        end
    endgenerate

    // Select the word requested by the copy engine.
    always_comb begin
        rd_data = bank_rd[rd_slot][rd_reg];
    end
endmodule

// File: rtl/crl_clone_engine.sv
// Accepts clone commands for complete slots and copies the selected owed
// registers into the register file, lowest index first, one per cycle.
// Releases the slot when the copy ends.
// Assumes: the parent holds a clone request until clone_stall is low.
module crl_clone_engine #(
    parameter int unsigned NUM_SLOTS = crl_pkg::DEF_SLOTS,
    parameter int unsigned NUM_REGS  = crl_pkg::DEF_REGS,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
    localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clone_valid,
    input  logic [SLOT_W-1:0]                  clone_slot,
    input  logic [NUM_REGS-1:0]                clone_sel,
    input  logic [NUM_SLOTS-1:0]               returned_i,
    input  logic [NUM_SLOTS-1:0][NUM_REGS-1:0] mask_i,
    output logic                               clone_stall,
    output logic                               copy_we,
    output logic [SLOT_W-1:0]                  rd_slot,
    output logic [REG_W-1:0]                   rd_reg,
    output logic                               free_valid,
    output logic [SLOT_W-1:0]                  free_slot
);
    import crl_pkg::*;

    eng_state_e          state_q;
    logic [SLOT_W-1:0]   slot_q;
    logic [NUM_REGS-1:0] pend_q;
    logic [NUM_REGS-1:0] sel_now;
    logic                accept;
    logic                last_word;

    // Index of the lowest set bit of a register selection.
    function automatic logic [REG_W-1:0] low_idx(input logic [NUM_REGS-1:0] v);
        logic [REG_W-1:0] idx;
        idx = '0;
        for (int i = NUM_REGS - 1; i >= 0; i--) begin
            if (v[i]) idx = REG_W'(i);
        end
        return idx;
    endfunction

    // Acceptance, copy port and release decisions.
    always_comb begin
        accept      = clone_valid && (state_q == ENG_IDLE) && returned_i[clone_slot];
        clone_stall = clone_valid && !accept;
        sel_now     = clone_sel & mask_i[clone_slot];
        last_word   = (pend_q & (pend_q - NUM_REGS'(1))) == '0;
        copy_we     = (state_q == ENG_COPY);
        rd_slot     = slot_q;
        rd_reg      = low_idx(pend_q);
        free_valid  = (accept && (sel_now == '0)) || ((state_q == ENG_COPY) && last_word);
        free_slot   = (state_q == ENG_COPY) ? slot_q : clone_slot;
    end

    // Copy sequencing: load the selection, retire one register per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            slot_q  <= '0;
            pend_q  <= '0;
        end else if (state_q == ENG_IDLE) begin
            if (accept && (sel_now != '0)) begin
                state_q <= ENG_COPY;
                slot_q  <= clone_slot;
                pend_q  <= sel_now;
            end
        end else begin
            pend_q <= pend_q & (pend_q - NUM_REGS'(1));
            if (last_word) begin
                state_q <= ENG_IDLE;
            end
        end
    end

    // R7: a clone aimed at an incomplete slot is never accepted.
    p_stall_incomplete_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clone_valid && !returned_i[clone_slot] |-> clone_stall)
        else $error("clone accepted on incomplete slot");

    // R6: back-to-back copy writes climb in register index.
    p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        copy_we && $past(copy_we) |-> rd_reg > $past(rd_reg))
        else $error("copy order not ascending");

    // R6: each copied register is owed by the slot being copied.
    p_copy_owed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        copy_we |-> mask_i[rd_slot][rd_reg] && returned_i[rd_slot])
        else $error("copy of an unowed register");
endmodule

// File: rtl/child_return_latch.sv
// Top of the child result return latch: slot table, latch banks and clone
// engine. Returned values are parked and only reach the register file through
// a parent clone command. The parent's end request waits on outstanding children.
// Assumes: one return word per cycle; hiring and transport live elsewhere.
module child_return_latch #(
    parameter int unsigned NUM_SLOTS = crl_pkg::DEF_SLOTS,
    parameter int unsigned NUM_REGS  = crl_pkg::DEF_REGS,
    parameter int unsigned DATA_W    = crl_pkg::DEF_DATA_W,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
    localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hire_valid,
    input  logic [SLOT_W-1:0]    hire_slot,
    input  logic [NUM_REGS-1:0]  hire_mask,
    input  logic                 ret_valid,
    input  logic [SLOT_W-1:0]    ret_slot,
    input  logic [REG_W-1:0]     ret_reg,
    input  logic [DATA_W-1:0]    ret_data,
    input  logic                 clone_valid,
    input  logic [SLOT_W-1:0]    clone_slot,
    input  logic [NUM_REGS-1:0]  clone_sel,
    output logic                 clone_stall,
    output logic                 rf_we,
    output logic [REG_W-1:0]     rf_addr,
    output logic [DATA_W-1:0]    rf_data,
    input  logic                 end_req,
    output logic                 end_wait,
    output logic                 end_grant,
    output logic [NUM_SLOTS-1:0] outstanding,
    output logic [NUM_SLOTS-1:0] slot_returned
);
    logic                               ret_accept;
    logic [NUM_SLOTS-1:0][NUM_REGS-1:0] slot_mask;
    logic [NUM_SLOTS-1:0]               slot_busy;
    logic                               free_valid;
    logic [SLOT_W-1:0]                  free_slot;
    logic [SLOT_W-1:0]                  rd_slot;
    logic [REG_W-1:0]                   rd_reg;

    crl_slot_table #(.NUM_SLOTS(NUM_SLOTS), .NUM_REGS(NUM_REGS)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .hire_valid (hire_valid),
        .hire_slot  (hire_slot),
        .hire_mask  (hire_mask),
        .ret_valid  (ret_valid),
        .ret_slot   (ret_slot),
        .ret_reg    (ret_reg),
        .free_valid (free_valid),
        .free_slot  (free_slot),
        .ret_accept (ret_accept),
        .mask_o     (slot_mask),
        .busy_o     (slot_busy),
        .returned_o (slot_returned)
    );

    crl_latch_bank #(.NUM_SLOTS(NUM_SLOTS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .wr_en   (ret_accept),
        .wr_slot (ret_slot),
        .wr_reg  (ret_reg),
        .wr_data (ret_data),
        .rd_slot (rd_slot),
        .rd_reg  (rd_reg),
        .rd_data (rf_data)
    );

    crl_clone_engine #(.NUM_SLOTS(NUM_SLOTS), .NUM_REGS(NUM_REGS)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .clone_valid (clone_valid),
        .clone_slot  (clone_slot),
        .clone_sel   (clone_sel),
        .returned_i  (slot_returned),
        .mask_i      (slot_mask),
        .clone_stall (clone_stall),
        .copy_we     (rf_we),
        .rd_slot     (rd_slot),
        .rd_reg      (rd_reg),
        .free_valid  (free_valid),
        .free_slot   (free_slot)
    );

    // Outstanding children and the end-of-fragment hold.
    always_comb begin
        outstanding = slot_busy & ~slot_returned;
        rf_addr     = rd_reg;
        end_wait    = end_req && (outstanding != '0);
        end_grant   = end_req && (outstanding == '0);
    end

    // R9: an end request with a child still owing is held, never granted.
    p_end_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        end_req && (slot_busy & ~slot_returned) != '0 |-> end_wait && !end_grant)
        else $error("end granted with outstanding child");

    // R8: a released slot is no longer complete in the next cycle.
    p_freed_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |=> !slot_returned[$past(free_slot)])
        else $error("slot still complete after release");

    // R5: the register file is written only after a clone was accepted.
    p_write_needs_clone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_we) |-> $past(clone_valid) && !$past(clone_stall))
        else $error("register write without clone");

    // R4: a newly hired slot with nothing owed is complete at once.
    p_zero_mask_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hire_valid && !slot_busy[hire_slot] && hire_mask == '0
        |=> slot_returned[$past(hire_slot)])
        else $error("zero-mask slot not complete");
endmodule

// File: tb/child_return_latch_bench.sv
`timescale 1ns/1ps
module child_return_latch_bench;
    localparam int NS = 8;
    localparam int NR = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          hire_valid;
    logic [2:0]    hire_slot;
    logic [NR-1:0] hire_mask;
    logic          ret_valid;
    logic [2:0]    ret_slot;
    logic [3:0]    ret_reg;
    logic [DW-1:0] ret_data;
    logic          clone_valid;
    logic [2:0]    clone_slot;
    logic [NR-1:0] clone_sel;
    logic          clone_stall;
    logic          rf_we;
    logic [3:0]    rf_addr;
    logic [DW-1:0] rf_data;
    logic          end_req;
    logic          end_wait;
    logic          end_grant;
    logic [NS-1:0] outstanding;
    logic [NS-1:0] slot_returned;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model of slot state.
    bit            m_busy [NS];
    logic [NR-1:0] m_mask [NS];
    logic [NR-1:0] m_vld  [NS];
    logic [DW-1:0] m_data [NS][NR];

    always #2 clk = ~clk;

    child_return_latch u_child_return_latch (
        .clk(clk), .rst_n(rst_n),
        .hire_valid(hire_valid), .hire_slot(hire_slot), .hire_mask(hire_mask),
        .ret_valid(ret_valid), .ret_slot(ret_slot), .ret_reg(ret_reg), .ret_data(ret_data),
        .clone_valid(clone_valid), .clone_slot(clone_slot), .clone_sel(clone_sel),
        .clone_stall(clone_stall), .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .end_req(end_req), .end_wait(end_wait), .end_grant(end_grant),
        .outstanding(outstanding), .slot_returned(slot_returned)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_done(input int s);
        return m_busy[s] && (m_vld[s] == m_mask[s]);
    endfunction

    function automatic logic [NS-1:0] exp_returned();
        logic [NS-1:0] v = '0;
        for (int s = 0; s < NS; s++) v[s] = exp_done(s);
        return v;
    endfunction

    function automatic logic [NS-1:0] exp_outstanding();
        logic [NS-1:0] v = '0;
        for (int s = 0; s < NS; s++) v[s] = m_busy[s] && !exp_done(s);
        return v;
    endfunction

    // Compare slot masks, write port idle and the end handshake (R1 R4 R5 R9).
    task automatic check_state(input string tag);
        logic [NS-1:0] eo;
        eo = exp_outstanding();
        chk(outstanding == eo, {tag, " R1 outstanding"}, DW'(outstanding), DW'(eo));
        chk(slot_returned == exp_returned(), {tag, " R4 returned"},
            DW'(slot_returned), DW'(exp_returned()));
        chk(rf_we == 1'b0, {tag, " R5 rf_we idle"}, DW'(rf_we), 0);
        end_req = 1'($urandom);
        #0.5;
        chk(end_wait == (end_req && eo != '0), {tag, " R9 end_wait"}, DW'(end_wait),
            DW'(end_req && eo != '0));
        chk(end_grant == (end_req && eo == '0), {tag, " R9 end_grant"}, DW'(end_grant),
            DW'(end_req && eo == '0));
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_hire(input int s, input logic [NR-1:0] m);
        hire_valid = 1'b1; hire_slot = 3'(s); hire_mask = m;
        @(posedge clk);
        if (!m_busy[s]) begin
            m_busy[s] = 1; m_mask[s] = m; m_vld[s] = '0;
        end
        @(negedge clk);
        hire_valid = 1'b0;
        check_state("hire");
    endtask

    task automatic do_ret(input int s, input int r, input logic [DW-1:0] d);
        ret_valid = 1'b1; ret_slot = 3'(s); ret_reg = 4'(r); ret_data = d;
        @(posedge clk);
        if (m_busy[s] && m_mask[s][r] && !exp_done(s)) begin
            m_vld[s][r] = 1'b1; m_data[s][r] = d;
        end
        @(negedge clk);
        ret_valid = 1'b0;
        check_state("return R3");
    endtask

    task automatic do_clone(input int s, input logic [NR-1:0] sel);
        logic [NR-1:0] pend;
        bit            exp_stall;
        clone_valid = 1'b1; clone_slot = 3'(s); clone_sel = sel;
        exp_stall = !exp_done(s);
        #0.5;
        chk(clone_stall == exp_stall, "R7 clone_stall", DW'(clone_stall), DW'(exp_stall));
        pend = sel & m_mask[s];
        next_cycle();
        clone_valid = 1'b0;
        if (exp_stall) begin
            check_state("stalled clone R7");
        end else begin
            for (int r = 0; r < NR; r++) begin
                if (pend[r]) begin
                    chk(rf_we == 1'b1, "R6 rf_we", DW'(rf_we), 1);
                    chk(rf_addr == 4'(r), "R6 rf_addr", DW'(rf_addr), DW'(r));
                    chk(rf_data == m_data[s][r], "R6 rf_data", rf_data, m_data[s][r]);
                    next_cycle();
                end
            end
            m_busy[s] = 0; m_vld[s] = '0;
            check_state("clone done R8");
        end
    endtask

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd20240611);
        rst_n = 1'b0; hire_valid = 0; hire_slot = 0; hire_mask = 0;
        ret_valid = 0; ret_slot = 0; ret_reg = 0; ret_data = 0;
        clone_valid = 0; clone_slot = 0; clone_sel = 0; end_req = 0;
        for (int s = 0; s < NS; s++) begin
            m_busy[s] = 0; m_mask[s] = '0; m_vld[s] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_state("reset R10");

        // Directed: mask kept, unowed and late writes dropped, stall, ordered copy.
        do_hire(2, 16'h0005);
        do_hire(2, 16'hFFFF);               // R2: ignored
        do_clone(2, 16'hFFFF);              // R7: stall, slot incomplete
        do_ret(2, 0, 32'hA0A0_0001);
        do_ret(2, 1, 32'hBAD0_0001);        // R3: unowed
        do_ret(2, 2, 32'hC0C0_0002);        // completes slot 2 (R4)
        do_ret(2, 0, 32'hBAD0_0002);        // R3: after completion
        do_clone(2, 16'hFFFF);              // R6: writes reg 0 then reg 2
        do_hire(2, 16'h8000);               // R8: freed slot accepts hire
        do_ret(2, 15, 32'h1515_1515);
        do_clone(2, 16'h8001);
        do_hire(5, 16'h0000);               // R4: zero mask
        do_clone(5, 16'hFFFF);              // R8: nothing selected, freed

        // Random traffic.
        for (int i = 0; i < 1500; i++) begin
            int op;
            int s;
            op = int'($urandom % 4);
            s  = int'($urandom % NS);
            case (op)
                0: do_hire(s, NR'($urandom & $urandom & $urandom));
                1: begin
                    int r;
                    r = int'($urandom % NR);
                    if ($urandom % 4 != 0) begin
                        for (int k = 0; k < NR; k++)
                            if (m_mask[s][k] && !m_vld[s][k]) r = k;
                    end
                    do_ret(s, r, $urandom);
                end
                2: do_clone(s, NR'($urandom));
                default: begin
                    next_cycle();
                    check_state("idle");
                end
            endcase
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule